// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block is a small real-time clock on a simple register bus. It keeps a 32-bit count of elapsed seconds. A prescaler counts pulses on a slow-clock enable input and, after a programmable number of pulses, advances the count by one second. Software can load a new count, which also restarts the prescaler. Software can read the count at any time. A control bit stops and starts the clock.

A 32-bit compare register holds an alarm time. When a seconds step makes the count equal to that value, the block sets a sticky raw alarm flag. The flag can always be read, whether or not the alarm is masked. A one-bit mask enables it onto a masked status view and onto the interrupt pin. Software writes a one to a clear register to drop the flag.

Bus access is a single cycle. A write takes effect at the clock edge where select and write are both high. Read data is combinational from the address while select is high and write is low. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `rtc_secs_alarm`

## Requirements
- R1: After reset the count, the alarm compare value, the mask and the raw flag are all zero, the run bit reads 1, and `irq` is low.
- R2: A write to the load register at byte offset 0x08 sets the count to the written value and restarts the prescaler. A tick pulse in the same cycle as the load is not counted. The count then steps exactly on the edge that samples the DIV-th later `tick_en` pulse. The load register reads as zero.
- R3: While run is 1, the count rises by one on every DIV-th `tick_en` pulse, and cycles without a pulse are not counted. The count wraps from 0xFFFFFFFF to 0. It is read at offset 0x00.
- R4: Bit 0 of the control register at offset 0x0C is the run bit. While it is 0, both the prescaler and the count hold. Loads still take effect. Other bits of this register read as zero.
- R5: The raw alarm flag (bit 0 of offset 0x14) is set on the edge where a seconds step makes the count equal to the compare value. It is not set when a load, or a write to the compare register, makes the two equal.
- R6: The raw flag stays set until a write to offset 0x1C has bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect. If a step sets the flag in the same cycle as a clear, the flag stays set. Offset 0x1C reads as zero.
- R7: Masked status (bit 0 of offset 0x18) equals raw AND mask, and `irq` equals masked status. The raw flag stays readable while masked.
- R8: The mask register at offset 0x10 holds one writable bit, bit 0. Its upper bits read as zero.
- R9: Offsets 0x20 to 0x3C, and offsets that are not word aligned, read as zero and ignore writes. `rdata` is zero whenever no read access is in progress.
- R10: The compare register at offset 0x04 is a full 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the slow reference rate |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Alarm interrupt, level |

## Verification
Read data appears in the same cycle as the read strobe. Register writes show from the cycle after the edge that samples them. A seconds step, the raw flag it sets and the `irq` level it drives all change on the edge that samples the DIV-th prescaler pulse. The bench drives every input at the falling edge. It samples `rdata` one nanosecond later, against a reference model that has not yet been advanced. Only after that does it advance the model for the coming rising edge, and it checks `irq` just after that edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Word index of each register (byte offset >> 2); software depends on these.
  localparam logic [2:0] IDX_COUNT = 3'd0;
  localparam logic [2:0] IDX_MATCH = 3'd1;
  localparam logic [2:0] IDX_LOAD  = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd3;
  localparam logic [2:0] IDX_MASK  = 3'd4;
  localparam logic [2:0] IDX_RAW   = 3'd5;
  localparam logic [2:0] IDX_MSTAT = 3'd6;
  localparam logic [2:0] IDX_CLEAR = 3'd7;
  // Number of address bits covered by the register window.
  localparam int unsigned WIN_BITS = 5;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic restart,
  output logic sec_tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc_q, presc_d;
  logic          adv;

  assign adv      = run && tick_en && !restart;
  assign sec_tick = adv && (presc_q == LAST);

  always_comb begin
    presc_d = presc_q;
    if (restart)       presc_d = '0;
    else if (adv)      presc_d = (presc_q == LAST) ? '0 : presc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= LAST);
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(presc_q));
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (presc_q == '0));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          sec_tick,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] count,
  output logic          hit
);
  logic [CW-1:0] count_q, count_d, count_inc;

  assign count_inc = count_q + CW'(1);
  assign hit       = sec_tick && !ld && (count_inc == match_val);
  assign count     = count_q;

  always_comb begin
    count_d = count_q;
    if (ld)            count_d = ld_val;
    else if (sec_tick) count_d = count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (count_q == $past(ld_val)));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !ld) |=> (count_q == $past(count_q) + CW'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !ld) |=> $stable(count_q));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask_wr,
  input  logic mask_val,
  output logic raw,
  output logic mask,
  output logic masked
);
  logic raw_q, raw_d, mask_q, mask_d;

  always_comb begin
    raw_d  = set | (raw_q & ~clr);
    mask_d = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr) |=> raw_q);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> raw_q);
  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(set));
endmodule

// File: rtl/rtc_secs_alarm.sv
module rtc_secs_alarm #(
  parameter int unsigned DIV    = 32768,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  import rtc_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // Address decode.
  logic       mapped, wr_acc, rd_acc;
  logic [2:0] idx;
  assign mapped = (addr[1:0] == 2'b00) && ((addr >> WIN_BITS) == '0);
  assign idx    = addr[4:2];
  assign wr_acc = sel && wr && mapped;
  assign rd_acc = sel && !wr && mapped;

  logic ld_en, match_en, ctrl_en, mask_en, clr_en;
  assign ld_en    = wr_acc && (idx == IDX_LOAD);
  assign match_en = wr_acc && (idx == IDX_MATCH);
  assign ctrl_en  = wr_acc && (idx == IDX_CTRL);
  assign mask_en  = wr_acc && (idx == IDX_MASK);
  assign clr_en   = wr_acc && (idx == IDX_CLEAR) && wdata[0];

  // Compare value and run bit.
  logic [DW-1:0] match_q, match_d;
  logic          run_q, run_d;
  always_comb begin
    match_d = match_en ? wdata : match_q;
    run_d   = ctrl_en ? wdata[0] : run_q;
  end
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      match_q <= '0;
      run_q   <= 1'b1;
    end else begin
      match_q <= match_d;
      run_q   <= run_d;
    end
  end

  logic          sec_tick, hit, raw, mask, masked;
  logic [DW-1:0] count;

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(core_rst_n), .run(run_q), .tick_en(tick_en),
    .restart(ld_en), .sec_tick(sec_tick)
  );

  rtc_counter #(.CW(DW)) u_count (
    .clk(clk), .rst_n(core_rst_n), .ld(ld_en), .ld_val(wdata),
    .sec_tick(sec_tick), .match_val(match_q), .count(count), .hit(hit)
  );

  rtc_irq_status u_irq (
    .clk(clk), .rst_n(core_rst_n), .set(hit), .clr(clr_en),
    .mask_wr(mask_en), .mask_val(wdata[0]),
    .raw(raw), .mask(mask), .masked(masked)
  );

  assign irq = masked;

  // Read mux.
  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      unique case (idx)
        IDX_COUNT: rdata = count;
        IDX_MATCH: rdata = match_q;
        IDX_CTRL:  rdata = DW'(run_q);
        IDX_MASK:  rdata = DW'(mask);
        IDX_RAW:   rdata = DW'(raw);
        IDX_MSTAT: rdata = DW'(masked);
        default:   rdata = '0;
      endcase
    end
  end

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !sel |-> (rdata == '0));
  p_irq_raw_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq |-> raw);
endmodule

// File: tb/sim_rtc_secs_alarm.sv
module sim_rtc_secs_alarm;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, sel, wr;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  always #4 clk = ~clk;

  rtc_secs_alarm #(.DIV(DIV), .DW(32), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state.
  logic [31:0] m_count, m_match;
  int unsigned m_presc;
  logic        m_run, m_mask, m_raw;
  logic [31:0] rd_last;

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return m_count;
      6'h04: return m_match;
      6'h0C: return {31'b0, m_run};
      6'h10: return {31'b0, m_mask};
      6'h14: return {31'b0, m_raw};
      6'h18: return {31'b0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [5:0] a,
                     input logic [31:0] d, input logic t);
    logic [31:0] n_count, n_match;
    logic        n_run, n_mask, fire, clr;
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; tick_en = t;
    #1;
    rd_last = rdata;
    n_count = m_count; n_match = m_match; n_run = m_run; n_mask = m_mask;
    fire = 1'b0; clr = 1'b0;
    if (s && w && a == 6'h08) begin
      n_count = d; m_presc = 0;
    end else if (m_run && t) begin
      if (m_presc == DIV - 1) begin
        m_presc = 0;
        n_count = m_count + 32'd1;
        fire = (n_count == m_match);
      end else m_presc++;
    end
    if (s && w) begin
      case (a)
        6'h04: n_match = d;
        6'h0C: n_run   = d[0];
        6'h10: n_mask  = d[0];
        6'h1C: clr     = d[0];
        default: ;
      endcase
    end
    m_raw = fire | (m_raw & ~clr);
    m_count = n_count; m_match = n_match; m_run = n_run; m_mask = n_mask;
    @(posedge clk);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd_chk(input logic [5:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0);
    chk(req, rd_last, e);
  endtask

  task automatic irq_chk(input string req);
    #1;
    chk(req, {31'b0, irq}, {31'b0, m_raw & m_mask});
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 6'h00, 32'h0, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_en = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    m_count = '0; m_match = '0; m_presc = 0; m_run = 1'b1; m_mask = 1'b0; m_raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk(6'h00, "R1 count");
    rd_chk(6'h04, "R1 match");
    rd_chk(6'h10, "R1 mask");
    rd_chk(6'h14, "R1 raw");
    rd_chk(6'h0C, "R1 run");

    // R2: load then DIV pulses
    wr_reg(6'h08, 32'h0000_1234);
    rd_chk(6'h08, "R2 load reads zero");
    pulses(DIV - 1);
    rd_chk(6'h00, "R2 before step");
    chk("R2 no step yet", rd_last, 32'h0000_1234);
    pulses(1);
    rd_chk(6'h00, "R2 after step");
    chk("R2 stepped", rd_last, 32'h0000_1235);

    // R3: idle cycles do not count
    repeat (5) cyc(1'b0, 1'b0, 6'h00, 32'h0, 1'b0);
    rd_chk(6'h00, "R3 idle hold");

    // R3/R5/R7: wrap to zero hits compare value zero
    wr_reg(6'h04, 32'h0);
    rd_chk(6'h04, "R10 match");
    wr_reg(6'h10, 32'hFFFF_FFFF);
    rd_chk(6'h10, "R8 mask upper bits");
    wr_reg(6'h08, 32'hFFFF_FFFF);
    pulses(DIV);
    rd_chk(6'h00, "R3 wrap");
    chk("R3 wrap value", rd_last, 32'h0);
    rd_chk(6'h14, "R5 raw on wrap");
    chk("R5 raw set", rd_last, 32'h1);
    irq_chk("R7 irq asserted");
    rd_chk(6'h18, "R7 masked");

    // R7: mask off, raw still visible
    wr_reg(6'h10, 32'h0);
    irq_chk("R7 irq masked");
    rd_chk(6'h14, "R7 raw while masked");
    chk("R7 raw visible", rd_last, 32'h1);

    // R6: clear with bit0 = 0 then 1
    wr_reg(6'h1C, 32'hFFFF_FFFE);
    rd_chk(6'h14, "R6 clear zero no effect");
    rd_chk(6'h1C, "R6 clear reads zero");
    wr_reg(6'h1C, 32'h1);
    rd_chk(6'h14, "R6 cleared");
    chk("R6 cleared value", rd_last, 32'h0);

    // R5: load or compare write making equality does not set raw
    wr_reg(6'h04, 32'h0000_0050);
    wr_reg(6'h08, 32'h0000_0050);
    wr_reg(6'h04, 32'h0000_0050);
    rd_chk(6'h14, "R5 no set on load");
    chk("R5 raw still zero", rd_last, 32'h0);

    // R6: step sets in same cycle as clear
    wr_reg(6'h10, 32'h1);
    wr_reg(6'h04, 32'h0000_0011);
    wr_reg(6'h08, 32'h0000_0010);
    pulses(DIV - 1);
    cyc(1'b1, 1'b1, 6'h1C, 32'h1, 1'b1);
    rd_chk(6'h14, "R6 set beats clear");
    chk("R6 set kept", rd_last, 32'h1);
    irq_chk("R7 irq after set");
    wr_reg(6'h1C, 32'h1);

    // R4: run bit off holds the count, load still applies
    wr_reg(6'h0C, 32'h0);
    rd_chk(6'h0C, "R4 run off");
    pulses(3 * DIV);
    rd_chk(6'h00, "R4 hold");
    chk("R4 held", rd_last, 32'h0000_0011);
    wr_reg(6'h08, 32'h0000_0777);
    rd_chk(6'h00, "R4 load while stopped");
    wr_reg(6'h0C, 32'h1);
    pulses(DIV);
    rd_chk(6'h00, "R4 resumed");
    chk("R4 resumed value", rd_last, 32'h0000_0778);

    // R9: unmapped and misaligned
    wr_reg(6'h20, 32'hDEAD_BEEF);
    rd_chk(6'h20, "R9 unmapped read");
    wr_reg(6'h09, 32'h0000_0000);
    rd_chk(6'h00, "R9 misaligned write ignored");
    rd_chk(6'h05, "R9 misaligned read");
    cyc(1'b0, 1'b0, 6'h00, 32'h0, 1'b0);
    chk("R9 idle rdata", rd_last, 32'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic t;
      op = $urandom % 9;
      t  = 1'($urandom % 2);
      case (op)
        0: cyc(1'b1, 1'b1, 6'h04, m_count + ($urandom % 3), t);
        1: cyc(1'b1, 1'b1, 6'h08, (($urandom % 4) == 0) ? $urandom : m_match - ($urandom % 2), t);
        2: cyc(1'b1, 1'b1, 6'h10, $urandom, t);
        3: cyc(1'b1, 1'b1, 6'h1C, $urandom, t);
        4: cyc(1'b1, 1'b1, 6'h0C, {31'b0, ($urandom % 6) != 0}, t);
        5: cyc(1'b1, 1'b1, 6'(($urandom % 16) * 4 + 32'd32), $urandom, t);
        6, 7: begin
          logic [5:0] a;
          a = 6'(($urandom % 16) * 4);
          rd_chk(a, "RND read");
        end
        default: pulses(1 + ($urandom % DIV));
      endcase
      irq_chk("RND irq");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule